// File: doc/BRIEF.md
# Vector Length Control Unit

This unit holds the current vector length (VL) and the maximum vector length (MVL). It updates both from a 12-bit length-control field carried by a wide prefixed instruction. A decoder upstream extracts the field and presents it with `cmd_valid`.

The field selects one of two styles of update:

- **Loop style.** VL is taken either from a 5-bit immediate or from a scalar register. The register is fetched through a combinational read port.
- **One-shot style.** MVL is set, either alone or together with VL. When MVL is set alone, the current VL is cut down to fit under the new MVL.

The resulting VL can be returned to a destination scalar register through a one-cycle write-back pulse.

VL and MVL are also presented as a packed 32-bit state word for context save. The same layout can be loaded back through a restore strobe. Instruction decode and the element loop itself are outside this unit.

Field layout (bit positions within `cmd_ctl`):

| Bits | Meaning |
|------|---------|
| 11 | Style: 0 = loop style, 1 = one-shot style |
| 10:6 | Destination scalar register for the new VL |
| 5:1 | Immediate, or source register number |
| 0 | Sub-mode select |

Top module: `vlen_ctl_unit`

## Requirements
- R1: After reset, `vl` and `mvl` are both 1, and `wb_en` and `illegal` are 0.
- R2: A valid command whose 12-bit field is all zero leaves `vl` and `mvl` unchanged and produces no write-back.
- R3: With bit 11 = 0 and bit 0 = 0, VL becomes the immediate in bits 5:1 plus one on the next clock edge. MVL is unchanged, and this immediate is not limited by MVL.
- R4: With bit 11 = 0 and bit 0 = 1, `rd_addr` equals bits 5:1 in the same cycle. On the next edge VL becomes `rd_data` limited to the current MVL, with a value of zero taken as one.
- R5: With bit 11 = 0, bit 0 = 1 and bits 5:1 equal to zero, `illegal` is 1 for the following cycle. VL and MVL are unchanged and there is no write-back.
- R6: With bit 11 = 1 and bit 0 = 0, both VL and MVL become the immediate plus one.
- R7: With bit 11 = 1 and bit 0 = 1, MVL becomes the immediate plus one. VL keeps its value unless that value exceeds the new MVL, in which case VL becomes the new MVL.
- R8: For every legal, non-zero command whose bits 10:6 are non-zero, `wb_en` is 1 for exactly the following cycle. In that cycle `wb_addr` holds bits 10:6 and `wb_data` holds the new VL zero-extended. When bits 10:6 are zero, no write-back occurs.
- R9: `state_word` carries MVL in bits 5:0 and VL in bits 11:6. Bits 31:12 (the offset and sub-vector fields) read as zero.
- R10: When `restore_en` is high, MVL is loaded from `restore_word[5:0]` and VL from `restore_word[11:6]`. A zero field is loaded as 1, and VL is limited to the restored MVL. A restore overrides a command presented in the same cycle.
- R11: While `cmd_valid` and `restore_en` are both low, VL and MVL hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Length-control field is valid this cycle |
| cmd_ctl | input | 12 | Length-control field |
| rd_addr | output | 5 | Scalar register read address (source of VL) |
| rd_data | input | XLEN | Scalar register read data, same cycle |
| wb_en | output | 1 | Write-back of the new VL to a scalar register |
| wb_addr | output | 5 | Write-back destination register |
| wb_data | output | XLEN | Write-back value (new VL) |
| illegal | output | 1 | Command named x0 as the VL source |
| vl | output | 6 | Current vector length |
| mvl | output | 6 | Current maximum vector length |
| state_word | output | 32 | Packed state for context save |
| restore_en | input | 1 | Load state from `restore_word` |
| restore_word | input | 32 | Packed state for context restore |

## Verification
The register read is combinational, so `rd_addr` is checked in the same cycle that a command is driven. Every other result is registered once:

- `vl` and `mvl` change on the edge that accepts the command.
- `wb_en`, `wb_addr`, `wb_data` and `illegal` appear in the cycle after that edge.
- `state_word` follows the registers with no added delay.

The bench drives inputs on the falling edge and lets one rising edge pass. It then removes the command and compares all outputs on the following falling edge, which is exactly one cycle after the stimulus. This also confirms that the write-back and fault pulses last a single cycle.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int VLW   = 6;   // width of VL and MVL
  localparam int RAW   = 5;   // scalar register address width
  localparam int CTLW  = 12;  // width of the length-control field
  localparam int SWW   = 32;  // state word width

  typedef enum logic [2:0] {
    VM_NONE,
    VM_LOOP_IMM,
    VM_LOOP_REG,
    VM_SET_BOTH,
    VM_SET_MAX,
    VM_BAD_SRC
  } vl_mode_e;

  // immediate is stored offset by one
  function automatic logic [VLW-1:0] imm_len(input logic [RAW-1:0] imm);
    return VLW'(imm) + VLW'(1);
  endfunction

  // zero becomes one, then cap at the limit
  function automatic logic [VLW-1:0] fit_len(input logic [VLW-1:0] req,
                                             input logic [VLW-1:0] lim);
    logic [VLW-1:0] r;
    r = (req == '0) ? VLW'(1) : req;
    return (r > lim) ? lim : r;
  endfunction
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
(
  input  logic [CTLW-1:0] ctl,
  output vl_mode_e        mode,
  output logic [RAW-1:0]  imm,
  output logic [RAW-1:0]  dst
);
  assign imm = ctl[5:1];
  assign dst = ctl[10:6];

  always_comb begin
    if (ctl == '0)
      mode = VM_NONE;
    else if (!ctl[CTLW-1] && !ctl[0])
      mode = VM_LOOP_IMM;
    else if (!ctl[CTLW-1])
      mode = (ctl[5:1] == '0) ? VM_BAD_SRC : VM_LOOP_REG;
    else if (!ctl[0])
      mode = VM_SET_BOTH;
    else
      mode = VM_SET_MAX;
  end
endmodule

// File: rtl/vlc_next.sv
module vlc_next
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vl_mode_e        mode,
  input  logic [RAW-1:0]  imm,
  input  logic [XLEN-1:0] reg_val,
  input  logic [VLW-1:0]  cur_vl,
  input  logic [VLW-1:0]  cur_mvl,
  output logic [VLW-1:0]  nxt_vl,
  output logic [VLW-1:0]  nxt_mvl,
  output logic            takes_effect
);
  logic [VLW-1:0] reg_sat;
  logic [VLW-1:0] imm_v;

  // saturate the wide register value before narrowing
  assign reg_sat = (reg_val > XLEN'(cur_mvl)) ? cur_mvl : reg_val[VLW-1:0];
  assign imm_v   = imm_len(imm);

  always_comb begin
    nxt_vl       = cur_vl;
    nxt_mvl      = cur_mvl;
    takes_effect = 1'b1;
    unique case (mode)
      VM_LOOP_IMM: nxt_vl = imm_v;
      VM_LOOP_REG: nxt_vl = fit_len(reg_sat, cur_mvl);
      VM_SET_BOTH: begin
        nxt_vl  = imm_v;
        nxt_mvl = imm_v;
      end
      VM_SET_MAX: begin
        nxt_mvl = imm_v;
        nxt_vl  = fit_len(cur_vl, imm_v);
      end
      default: takes_effect = 1'b0;
    endcase
  end
endmodule

// File: rtl/vlen_ctl_unit.sv
module vlen_ctl_unit
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [11:0]       cmd_ctl,
  output logic [4:0]        rd_addr,
  input  logic [XLEN-1:0]   rd_data,
  output logic              wb_en,
  output logic [4:0]        wb_addr,
  output logic [XLEN-1:0]   wb_data,
  output logic              illegal,
  output logic [5:0]        vl,
  output logic [5:0]        mvl,
  output logic [31:0]       state_word,
  input  logic              restore_en,
  input  logic [31:0]       restore_word
);
  vl_mode_e       mode;
  logic [RAW-1:0] imm, dst;
  logic [VLW-1:0] nxt_vl, nxt_mvl;
  logic           takes_effect;

  // named events for the checker
  logic           cmd_take;
  logic           upd_fire;
  logic           fault_fire;
  logic           wb_fire;
  logic [VLW-1:0] rs_vl, rs_mvl;

  vlc_decode u_dec (
    .ctl  (cmd_ctl),
    .mode (mode),
    .imm  (imm),
    .dst  (dst)
  );

  vlc_next #(.XLEN(XLEN)) u_nxt (
    .mode         (mode),
    .imm          (imm),
    .reg_val      (rd_data),
    .cur_vl       (vl),
    .cur_mvl      (mvl),
    .nxt_vl       (nxt_vl),
    .nxt_mvl      (nxt_mvl),
    .takes_effect (takes_effect)
  );

  assign rd_addr    = imm;
  assign cmd_take   = cmd_valid && !restore_en;
  assign upd_fire   = cmd_take && takes_effect;
  assign fault_fire = cmd_take && (mode == VM_BAD_SRC);
  assign wb_fire    = upd_fire && (dst != '0);

  assign rs_mvl = fit_len(restore_word[5:0], {VLW{1'b1}});
  assign rs_vl  = fit_len(restore_word[11:6], rs_mvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl      <= VLW'(1);
      mvl     <= VLW'(1);
      wb_en   <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
      illegal <= 1'b0;
    end else begin
      wb_en   <= wb_fire;
      illegal <= fault_fire;
      if (wb_fire) begin
        wb_addr <= dst;
        wb_data <= XLEN'(nxt_vl);
      end
      if (restore_en) begin
        vl  <= rs_vl;
        mvl <= rs_mvl;
      end else if (upd_fire) begin
        vl  <= nxt_vl;
        mvl <= nxt_mvl;
      end
    end
  end

  assign state_word = {{(SWW-2*VLW){1'b0}}, vl, mvl};
endmodule

// File: rtl/vlen_ctl_unit_chk.sv
module vlen_ctl_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [11:0] cmd_ctl,
  input logic        restore_en,
  input logic        wb_en,
  input logic [4:0]  wb_addr,
  input logic [63:0] wb_data,
  input logic        illegal,
  input logic [5:0]  vl,
  input logic [5:0]  mvl
);
  logic x0_src, set_max_cmd;
  assign x0_src      = cmd_valid && !restore_en && !cmd_ctl[11] && cmd_ctl[0]
                       && (cmd_ctl[5:1] == 5'd0);
  assign set_max_cmd = cmd_valid && !restore_en && cmd_ctl[11] && cmd_ctl[0];

  p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vl != 6'd0) && (mvl != 6'd0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !restore_en) |=> ($stable(vl) && $stable(mvl)));

  p_zero_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !restore_en && cmd_ctl == 12'd0) |=> ($stable(vl) && $stable(mvl) && !wb_en));

  p_x0_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x0_src |=> (illegal && !wb_en && $stable(vl) && $stable(mvl)));

  p_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_max_cmd |=> (vl <= mvl));

  p_wb_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ((wb_data == {58'd0, vl}) && (wb_addr != 5'd0)));
endmodule

bind vlen_ctl_unit vlen_ctl_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ctl    (cmd_ctl),
  .restore_en (restore_en),
  .wb_en      (wb_en),
  .wb_addr    (wb_addr),
  .wb_data    (wb_data),
  .illegal    (illegal),
  .vl         (vl),
  .mvl        (mvl)
);

// File: tb/vlen_ctl_unit_test.sv
module vlen_ctl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [11:0] cmd_ctl = '0;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data = '0;
  logic        wb_en;
  logic [4:0]  wb_addr;
  logic [63:0] wb_data;
  logic        illegal;
  logic [5:0]  vl, mvl;
  logic [31:0] state_word;
  logic        restore_en = 1'b0;
  logic [31:0] restore_word = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vlen_ctl_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctl(cmd_ctl),
    .rd_addr(rd_addr), .rd_data(rd_data), .wb_en(wb_en), .wb_addr(wb_addr),
    .wb_data(wb_data), .illegal(illegal), .vl(vl), .mvl(mvl),
    .state_word(state_word), .restore_en(restore_en), .restore_word(restore_word)
  );

  // entry: ctl[33:22] regval[21:14] vl[13:8] mvl[7:2] wb[1] ill[0]
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {12'h83E, 8'd0,   6'd32, 6'd32, 1'b0, 1'b0}, // R6 both=32
    {12'h0D2, 8'd0,   6'd10, 6'd32, 1'b1, 1'b0}, // R3 imm 10, dst x3
    {12'h1CB, 8'd20,  6'd20, 6'd32, 1'b1, 1'b0}, // R4 reg 20, dst x7
    {12'h00B, 8'd200, 6'd32, 6'd32, 1'b0, 1'b0}, // R4 clamp to MVL
    {12'h00B, 8'd0,   6'd1,  6'd32, 1'b0, 1'b0}, // R4 zero taken as one
    {12'h89F, 8'd0,   6'd1,  6'd16, 1'b1, 1'b0}, // R7 MVL 16, VL stays
    {12'h03A, 8'd0,   6'd30, 6'd16, 1'b0, 1'b0}, // R3 not limited by MVL
    {12'h84F, 8'd0,   6'd8,  6'd8,  1'b1, 1'b0}, // R7 truncation
    {12'h827, 8'd0,   6'd8,  6'd20, 1'b0, 1'b0}, // R7 MVL grows, VL kept
    {12'h101, 8'd0,   6'd8,  6'd20, 1'b0, 1'b1}, // R5 x0 source
    {12'h000, 8'd0,   6'd8,  6'd20, 1'b0, 1'b0}, // R2 all-zero field
    {12'h7C0, 8'd0,   6'd1,  6'd20, 1'b1, 1'b0}  // R8 dst x31, imm 0
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, then sample at next negedge
  task automatic step(input logic v, input logic [11:0] c, input logic [63:0] rv,
                      input logic rs, input logic [31:0] rw);
    cmd_valid = v; cmd_ctl = c; rd_data = rv; restore_en = rs; restore_word = rw;
    #1;
    if (v && !c[11] && c[0]) check("R4 rd_addr", 64'(rd_addr), 64'(c[5:1]));
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; restore_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 vl", 64'(vl), 64'd1);
    check("R1 mvl", 64'(mvl), 64'd1);
    check("R1 wb_en", 64'(wb_en), 64'd0);
    check("R1 illegal", 64'(illegal), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] c;
      c = VEC[i][33:22];
      step(1'b1, c, 64'(VEC[i][21:14]), 1'b0, 32'd0);
      check("R3/R4/R6/R7 vl", 64'(vl), 64'(VEC[i][13:8]));
      check("R6/R7 mvl", 64'(mvl), 64'(VEC[i][7:2]));
      check("R8 wb_en", 64'(wb_en), 64'(VEC[i][1]));
      check("R5 illegal", 64'(illegal), 64'(VEC[i][0]));
      if (VEC[i][1]) begin
        check("R8 wb_addr", 64'(wb_addr), 64'(c[10:6]));
        check("R8 wb_data", wb_data, 64'(VEC[i][13:8]));
      end
      @(negedge clk);
      check("R8 one-cycle pulse", 64'(wb_en), 64'd0);
    end

    // R11 idle with a live-looking field
    step(1'b0, 12'h83E, 64'd0, 1'b0, 32'd0);
    check("R11 vl", 64'(vl), 64'd1);
    check("R11 mvl", 64'(mvl), 64'd20);

    // R9 state word layout: vl=1 mvl=20
    check("R9 state_word", 64'(state_word), 64'(32'd20 | (32'd1 << 6)));

    // R10 restore: vl 50, mvl 40 -> vl limited to 40; overrides a command
    step(1'b1, 12'h83E, 64'd0, 1'b1, (32'd50 << 6) | 32'd40 | 32'hFFFF_F000);
    check("R10 vl", 64'(vl), 64'd40);
    check("R10 mvl", 64'(mvl), 64'd40);
    check("R10 no wb", 64'(wb_en), 64'd0);
    check("R9 state_word", 64'(state_word), 64'((32'd40 << 6) | 32'd40));

    // R10 zero fields become one
    step(1'b0, 12'h000, 64'd0, 1'b1, 32'd0);
    check("R10 zero vl", 64'(vl), 64'd1);
    check("R10 zero mvl", 64'(mvl), 64'd1);

    // R4 wide register value above MVL with low bits zero
    step(1'b1, 12'h1CB, 64'h1_0000_0000, 1'b0, 32'd0);
    check("R4 wide clamp", 64'(vl), 64'd1);
    check("R8 wb_data wide", wb_data, 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule